// File: doc/BRIEF.md
# Two-Operand NaN Propagation Unit

This block decides the result of a two-input binary32 floating-point operation when at least one operand is a NaN. It classifies both operands as ordinary numbers, quiet NaNs or signaling NaNs. It then picks which operand's NaN survives, using one of three static selection rule sets. The chosen NaN is quieted if needed, or a canonical NaN is substituted. The block also reports whether the operation must raise the invalid-operation exception. It sits beside the arithmetic datapath and takes over the result whenever a NaN input is detected.

Two static controls tune the block to the host architecture. A polarity pin states whether a set fraction MSB means quiet or signaling, and this choice affects both detection and quieting. A default-NaN mode pin forces the canonical NaN onto every result.

Operands enter through a valid/ready stream and the result leaves on a second valid/ready stream, one register stage later. An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new pair is accepted. The three control pins are sampled together with the operands.

Top module: `nanprop_unit`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. With `snan_msb_one`=0, a NaN whose fraction MSB (bit 22) is 1 is quiet and one whose bit 22 is 0 is signaling. With `snan_msb_one`=1 the meaning of bit 22 is reversed. An infinity is not a NaN. Every result delivered is a NaN.
- R2: With `sel_policy`=0 the result is taken from the first operand that matches, checked in this order: A signaling, B signaling, A quiet, else B. `sel_policy`=3 behaves the same as 0.
- R3: With `sel_policy`=1 the result is taken from A whenever A is any NaN, otherwise from B.
- R4: With `sel_policy`=2 the selection follows these rules. A NaN paired with a non-NaN gives the NaN. A signaling NaN paired with a quiet NaN gives the quiet one. Two NaNs of the same kind give the one with the larger significand.
- R5: Under `sel_policy`=2, significands are compared as the unsigned encodings with the sign bit removed. On a tie, A wins only when A's raw 32-bit encoding is numerically smaller than B's, so the positive one wins.
- R6: `out_invalid` is 1 exactly when at least one operand is a signaling NaN. This also holds in default-NaN mode.
- R7: With `dflt_mode`=1 the result is always the default NaN of the current polarity.
- R8: When the selected operand is signaling and `snan_msb_one`=0, the result is that operand with bit 22 set. When `snan_msb_one`=1, the result is the default NaN.
- R9: The default NaN has sign 0 and exponent all ones. Its fraction is 0x400000 when `snan_msb_one`=0 (word 0x7FC00000) and 0x3FFFFF when `snan_msb_one`=1 (word 0x7FBFFFFF).
- R10: A pair is accepted on an edge with `in_valid` and `in_ready` high, and its result is presented on the next cycle with `out_valid` high. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_result` and `out_invalid` stay unchanged and new pairs are refused.
- R11: Reset (`rst_n` low) clears `out_valid`, so `in_ready` is 1 after reset.
- R12: An accepted pair must contain at least one NaN. If neither operand is a NaN the result is unspecified and an input-contract assertion fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_a | input | 32 | Operand A, binary32 encoding |
| in_b | input | 32 | Operand B, binary32 encoding |
| sel_policy | input | 2 | Selection rule set: 0 ordered, 1 first NaN, 2 magnitude, 3 as 0 |
| snan_msb_one | input | 1 | 1 when a set fraction MSB marks a signaling NaN |
| dflt_mode | input | 1 | Force the default NaN as result |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_result | output | 32 | Propagated NaN |
| out_invalid | output | 1 | Invalid-operation exception for this pair |

## Verification
The checker watches several properties on every cycle. Every delivered result is a NaN, and the output stays frozen under back-pressure. Each accepted pair produces a result on the next cycle. The invalid flag follows the presence of a signaling input, and default-NaN mode yields the canonical word of the sampled polarity. With polarity 0, a non-default result always has the quiet bit set. The input contract of at least one NaN is also checked on every cycle. Which operand each policy selects, including the significand tie-break and the sign tie, can only be shown by the bench's directed scenarios with known expected words. The same holds for the reversed polarity and the infinity case.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

  // Operand classes used by the selection logic.
  typedef enum logic [1:0] {
    CLS_NUM    = 2'd0,
    CLS_QUIET  = 2'd1,
    CLS_SIGNAL = 2'd2
  } nan_cls_e;

  // Selection rule sets; code 3 falls back to the ordered rule.
  typedef enum logic [1:0] {
    POL_ORDERED   = 2'd0,
    POL_FIRST_NAN = 2'd1,
    POL_MAGNITUDE = 2'd2,
    POL_SPARE     = 2'd3
  } sel_pol_e;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  input  logic                    snan_msb_one,
  output nan_cls_e                cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              is_nan;
  logic              msb_signals;

  assign exp_f  = mag[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = mag[FRAC_W-1:0];
  assign is_nan = (&exp_f) && (|frac_f);
  // The MSB marks a signaling NaN when it matches the polarity pin.
  assign msb_signals = (frac_f[FRAC_W-1] == snan_msb_one);

  always_comb begin
    if (!is_nan)          cls = CLS_NUM;
    else if (msb_signals) cls = CLS_SIGNAL;
    else                  cls = CLS_QUIET;
  end
endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
  import nanprop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  nan_cls_e     cls_a,
  input  nan_cls_e     cls_b,
  input  logic [1:0]   policy,
  output logic         take_b
);
  logic a_sig, b_sig, a_qui, b_qui, a_any;
  logic a_wins_mag;

  assign a_sig = (cls_a == CLS_SIGNAL);
  assign b_sig = (cls_b == CLS_SIGNAL);
  assign a_qui = (cls_a == CLS_QUIET);
  assign b_qui = (cls_b == CLS_QUIET);
  assign a_any = a_sig | a_qui;

  // Magnitude without sign; on equal magnitude the smaller raw word wins.
  always_comb begin
    if (opa[W-2:0] > opb[W-2:0])      a_wins_mag = 1'b1;
    else if (opa[W-2:0] < opb[W-2:0]) a_wins_mag = 1'b0;
    else                              a_wins_mag = (opa < opb);
  end

  always_comb begin
    unique case (sel_pol_e'(policy))
      POL_FIRST_NAN: take_b = !a_any;
      POL_MAGNITUDE: begin
        if (a_sig)      take_b = b_sig ? !a_wins_mag : b_qui;
        else if (a_qui) take_b = b_qui ? !a_wins_mag : 1'b0;
        else            take_b = 1'b1;
      end
      default: begin
        if (a_sig)      take_b = 1'b0;
        else if (b_sig) take_b = 1'b1;
        else            take_b = !a_qui;
      end
    endcase
  end
endmodule

// File: rtl/nanprop_finish.sv
module nanprop_finish
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] chosen,
  input  nan_cls_e              chosen_cls,
  input  logic                  snan_msb_one,
  input  logic                  dflt_mode,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [W-1:0] canon;
  logic [W-1:0] quieted;

  // Canonical NaN: positive, exponent all ones, fraction set by polarity.
  always_comb begin
    canon                    = '0;
    canon[W-2:FRAC_W]        = '1;
    if (snan_msb_one) canon[FRAC_W-2:0] = '1;
    else              canon[FRAC_W-1]   = 1'b1;
  end

  always_comb begin
    quieted             = chosen;
    quieted[FRAC_W-1]   = 1'b1;
  end

  always_comb begin
    if (dflt_mode)                          result = canon;
    else if (chosen_cls != CLS_SIGNAL)      result = chosen;
    else if (snan_msb_one)                  result = canon;
    else                                    result = quieted;
  end
endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [EXP_W+FRAC_W:0]     in_a,
  input  logic [EXP_W+FRAC_W:0]     in_b,
  input  logic [1:0]                sel_policy,
  input  logic                      snan_msb_one,
  input  logic                      dflt_mode,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_W+FRAC_W:0]     out_result,
  output logic                      out_invalid
);
  localparam int W       = 1 + EXP_W + FRAC_W;
  localparam int N_OPND  = 2;

  logic [W-1:0] opnd [N_OPND];
  nan_cls_e     cls  [N_OPND];
  logic         take_b;
  logic [W-1:0] chosen;
  nan_cls_e     chosen_cls;
  logic [W-1:0] result_d;
  logic         invalid_d;
  logic         accept;

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
    nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .mag          (opnd[gi][W-2:0]),
      .snan_msb_one (snan_msb_one),
      .cls          (cls[gi])
    );
  end

  nanprop_pick #(.W(W)) u_pick (
    .opa    (in_a),
    .opb    (in_b),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .policy (sel_policy),
    .take_b (take_b)
  );

  assign chosen     = take_b ? in_b : in_a;
  assign chosen_cls = take_b ? cls[1] : cls[0];
  assign invalid_d  = (cls[0] == CLS_SIGNAL) || (cls[1] == CLS_SIGNAL);

  nanprop_finish #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fin (
    .chosen       (chosen),
    .chosen_cls   (chosen_cls),
    .snan_msb_one (snan_msb_one),
    .dflt_mode    (dflt_mode),
    .result       (result_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_result  <= result_d;
      out_invalid <= invalid_d;
    end
  end
endmodule

// File: rtl/nanprop_chk.sv
module nanprop_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [EXP_W+FRAC_W:0] in_a,
  input logic [EXP_W+FRAC_W:0] in_b,
  input logic                  snan_msb_one,
  input logic                  dflt_mode,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] out_result,
  input logic                  out_invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] CANON_Q = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] CANON_S = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic fire, a_nan, b_nan, a_sig, b_sig;
  assign fire  = in_valid && in_ready;
  assign a_nan = (&in_a[W-2:FRAC_W]) && (|in_a[FRAC_W-1:0]);
  assign b_nan = (&in_b[W-2:FRAC_W]) && (|in_b[FRAC_W-1:0]);
  assign a_sig = a_nan && (in_a[FRAC_W-1] == snan_msb_one);
  assign b_sig = b_nan && (in_b[FRAC_W-1] == snan_msb_one);

  p_result_is_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((&out_result[W-2:FRAC_W]) && (|out_result[FRAC_W-1:0])));

  p_invalid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (a_sig || b_sig)) |=> out_invalid);

  p_invalid_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(a_sig || b_sig)) |=> !out_invalid);

  p_dflt_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dflt_mode) |=>
      (out_result == ($past(snan_msb_one) ? CANON_S : CANON_Q)));

  p_quiet_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dflt_mode && !snan_msb_one) |=> out_result[FRAC_W-1]);

  p_accept_to_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_invalid)));

  p_operand_nan_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (a_nan || b_nan));
endmodule

bind nanprop_unit nanprop_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_a         (in_a),
  .in_b         (in_b),
  .snan_msb_one (snan_msb_one),
  .dflt_mode    (dflt_mode),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_invalid  (out_invalid)
);

// File: tb/tb_nanprop_unit.sv
module tb_nanprop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [1:0]  sel_policy = 2'd0;
  logic        snan_msb_one = 1'b0;
  logic        dflt_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;

  // Operand words for polarity 0.
  localparam logic [31:0] QA  = 32'h7FC00001;
  localparam logic [31:0] QB  = 32'hFFC00002;
  localparam logic [31:0] SA  = 32'h7F800005;
  localparam logic [31:0] SB  = 32'h7F900000;
  localparam logic [31:0] NUM = 32'h3F800000;
  localparam logic [31:0] INF = 32'h7F800000;

  always #5ns clk = ~clk;

  nanprop_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .sel_policy(sel_policy),
    .snan_msb_one(snan_msb_one), .dflt_mode(dflt_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_invalid(out_invalid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // One accepted pair, then sample the registered result one cycle later.
  task automatic xact(input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] pol, input logic sp, input logic dm,
                      input logic [31:0] exp_r, input logic exp_inv,
                      input string tag);
    @(negedge clk);
    in_a = a; in_b = b; sel_policy = pol; snan_msb_one = sp; dflt_mode = dm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(out_result == exp_r, {tag, " result"}, out_result, exp_r);
    check(out_invalid == exp_inv, {tag, " invalid"}, {31'd0, out_invalid},
          {31'd0, exp_inv});
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R11 in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_policy_ordered;
    xact(QA, SB, 2'd0, 1'b0, 1'b0, 32'h7FD00000, 1'b1, "R2 quiet A, signaling B");
    xact(SA, SB, 2'd0, 1'b0, 1'b0, 32'h7FC00005, 1'b1, "R2 two signaling R8");
    xact(QA, QB, 2'd0, 1'b0, 1'b0, QA, 1'b0, "R2 two quiet");
    xact(NUM, QB, 2'd0, 1'b0, 1'b0, QB, 1'b0, "R2 number A");
    xact(QA, SB, 2'd3, 1'b0, 1'b0, 32'h7FD00000, 1'b1, "R2 code 3");
  endtask

  task automatic t_policy_first;
    xact(QA, SB, 2'd1, 1'b0, 1'b0, QA, 1'b1, "R3 quiet A over signaling B");
    xact(NUM, SB, 2'd1, 1'b0, 1'b0, 32'h7FD00000, 1'b1, "R3 number A");
    xact(SA, QB, 2'd1, 1'b0, 1'b0, 32'h7FC00005, 1'b1, "R3 signaling A");
    xact(INF, QA, 2'd1, 1'b0, 1'b0, QA, 1'b0, "R1 infinity is no NaN");
  endtask

  task automatic t_policy_magnitude;
    xact(SA, QB, 2'd2, 1'b0, 1'b0, QB, 1'b1, "R4 signaling A, quiet B");
    xact(QB, SA, 2'd2, 1'b0, 1'b0, QB, 1'b1, "R4 quiet A, signaling B");
    xact(QA, QB, 2'd2, 1'b0, 1'b0, QB, 1'b0, "R4 two quiet larger B");
    xact(SA, SB, 2'd2, 1'b0, 1'b0, 32'h7FD00000, 1'b1, "R4 two signaling larger B");
    xact(SA, NUM, 2'd2, 1'b0, 1'b0, 32'h7FC00005, 1'b1, "R4 signaling with number");
    xact(NUM, QA, 2'd2, 1'b0, 1'b0, QA, 1'b0, "R4 number with quiet");
  endtask

  task automatic t_magnitude_tie;
    xact(32'hFFC00001, 32'h7FC00001, 2'd2, 1'b0, 1'b0, 32'h7FC00001, 1'b0,
         "R5 tie negative A");
    xact(32'h7FC00003, 32'hFFC00003, 2'd2, 1'b0, 1'b0, 32'h7FC00003, 1'b0,
         "R5 tie positive A");
  endtask

  task automatic t_default_mode;
    xact(QA, QB, 2'd0, 1'b0, 1'b1, 32'h7FC00000, 1'b0, "R7 quiet pair R9");
    xact(SA, NUM, 2'd2, 1'b0, 1'b1, 32'h7FC00000, 1'b1, "R6 signaling in default mode");
    xact(32'h7F800003, 32'h7FC00000, 2'd1, 1'b1, 1'b1, 32'h7FBFFFFF, 1'b1,
         "R7 polarity 1 R9");
  endtask

  task automatic t_inverted_polarity;
    // Polarity 1: 7F800003 is quiet, 7FC00000 is signaling.
    xact(32'h7F800003, 32'h7FC00000, 2'd0, 1'b1, 1'b0, 32'h7FBFFFFF, 1'b1,
         "R8 polarity 1 signaling chosen");
    xact(32'h7F800003, 32'hFF800009, 2'd0, 1'b1, 1'b0, 32'h7F800003, 1'b0,
         "R1 polarity 1 quiet kept");
    xact(QA, NUM, 2'd1, 1'b1, 1'b0, 32'h7FBFFFFF, 1'b1,
         "R1 polarity 1 msb set signals");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_a = QA; in_b = QB; sel_policy = 2'd0; snan_msb_one = 1'b0; dflt_mode = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check(out_result == QA, "R10 first result", out_result, QA);
    check(in_ready == 1'b0, "R10 refuse while stalled", {31'd0, in_ready}, 32'd0);
    in_a = NUM; in_b = SB;
    @(negedge clk);
    check(out_result == QA, "R10 held under stall", out_result, QA);
    check(out_invalid == 1'b0, "R10 flag held", {31'd0, out_invalid}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_result == 32'h7FD00000, "R10 second result", out_result, 32'h7FD00000);
    check(out_invalid == 1'b1, "R10 second flag", {31'd0, out_invalid}, 32'd1);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_policy_ordered();
    t_policy_first();
    t_policy_magnitude();
    t_magnitude_tie();
    t_default_mode();
    t_inverted_polarity();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200us;
    checks++;
    errors++;
    $display("FAIL watchdog: actual %08h expected %08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule